// File: doc/BRIEF.md
# Secure-Section Commit Time Equalizer

This block sits next to the retire stage of an out-of-order core and hides data-dependent timing inside marked secure code sections. Software brackets a secure section with an opening marker instruction and a closing marker instruction. When the opening marker retires, the block starts counting cycles. When the closing marker reaches the head of the retire stage, the block decides whether it may commit. If the section has run for fewer cycles than a target length, the block holds the commit-enable signal low. The closing marker and everything behind it then wait at the head until the target length has passed. Instructions inside the section retire at their normal pace, and execution is never slowed: only retirement of the closing marker is delayed.

In the default mode, the target is the longest section length the block has seen so far. That value lives in a saturating register which grows whenever a run reaches or exceeds it, so any observer sees every section take the worst case recorded up to that point. In the randomized mode, which is latched when a section opens, the target is instead a uniformly drawn multiple (1 to 256) of a programmable unit length. The draw comes from an internal 16-bit LFSR whose seed is loaded through a configuration input. Only one section can be open at a time. An opening marker seen while a section is already open is treated as an ordinary instruction and raises a sticky error flag.

Top module: `sce_equalizer`

## Requirements
- R1: `commit_en` is low only when a section is open, `head_valid` is high, `head_end` is high and the elapsed count is below the latched target. In every other cycle it is high, so instructions before the closing marker, and all instructions outside a section, commit without delay.
- R2: A section opens on the cycle its opening marker commits (`head_valid` and `head_begin` high while no section is open). `active` is high from the following cycle until the closing marker commits. The elapsed count equals the number of cycles since the opening commit.
- R3: In default mode, when the closing marker is presented after e cycles and e is less than the recorded length L, it commits exactly L cycles after the opening marker committed, and `rec_len` keeps the value L.
- R4: In default mode, when e is greater than or equal to L, the closing marker commits without a stall, e cycles after the opening commit, and `rec_len` becomes e.
- R5: The elapsed count and `rec_len` saturate at 2^CNT_W-1. A longer section commits without a stall and leaves `rec_len` at the maximum.
- R6: `rec_len` resets to 0. A cycle with `clear_rec` high sets it to 0 on the next edge.
- R7: An opening marker that arrives while a section is open commits normally. It does not restart the count or change the target, and it sets `nest_err`, which stays high until reset.
- R8: A closing marker that arrives while no section is open commits immediately and leaves `rec_len` and `active` unchanged.
- R9: If `rand_mode` is high when a section opens, the target is min((k+1)·`rand_unit`, 2^CNT_W-1), where k is bits [7:0] of the LFSR. The LFSR is a 16-bit right-shifting Galois register: when the shifted-out bit 0 is 1, the shifted value is XORed with 16'hB400. It advances once on each opening commit, after the draw. `seed_load` writes `seed_val` into the LFSR, and a zero seed is replaced by 1. The LFSR resets to 1. A randomized section never changes `rec_len`.
- R10: In randomized mode, if the elapsed time already reaches the drawn target when the closing marker arrives, the marker commits without a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | Retire-stage head holds an instruction ready to commit |
| head_begin | input | 1 | Head instruction is an opening marker |
| head_end | input | 1 | Head instruction is a closing marker |
| commit_en | output | 1 | Head instruction may commit this cycle |
| rand_mode | input | 1 | Use a randomized target for the next section that opens |
| rand_unit | input | UNIT_W | Unit length multiplied by the random factor |
| seed_load | input | 1 | Load `seed_val` into the LFSR |
| seed_val | input | 16 | LFSR seed |
| clear_rec | input | 1 | Reset the recorded worst-case length to zero |
| active | output | 1 | A secure section is open |
| rec_len | output | CNT_W | Recorded worst-case section length |
| nest_err | output | 1 | Sticky flag for an opening marker seen inside an open section |

## Verification
The checker assumes that the head instruction commits whenever `head_valid` and `commit_en` are both high, so a stalled closing marker stays at the head until it is released. It also assumes that no instruction carries both markers at once. The bench drives a retire-head model that meets both assumptions: it presents one instruction per cycle, keeps the closing marker in place while `commit_en` is low, and never sets both marker flags together. It also never loads a seed in the same cycle an opening marker commits, so every random draw comes from a well-defined LFSR state that the bench can replay.

// File: rtl/sce_pkg.sv
package sce_pkg;
    localparam int LFSR_W    = 16;
    localparam int DRAW_W    = 8;
    localparam logic [LFSR_W-1:0] LFSR_POLY  = 16'hB400;
    localparam logic [LFSR_W-1:0] LFSR_RESET = 16'h0001;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        logic [LFSR_W-1:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ LFSR_POLY;
        return n;
    endfunction
endpackage

// File: rtl/sce_lfsr.sv
module sce_lfsr
    import sce_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    input  logic              step,
    output logic [LFSR_W-1:0] state
);
    logic [LFSR_W-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d = (seed == '0) ? LFSR_RESET : seed;
        end else if (step) begin
            st_d = lfsr_step(st_q);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LFSR_RESET;
        else        st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/sce_elapsed.sv
module sce_elapsed #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(1);
        end else if (run && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/sce_target.sv
module sce_target
    import sce_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int UNIT_W = 8
) (
    input  logic [DRAW_W-1:0] draw,
    input  logic [UNIT_W-1:0] unit,
    output logic [CNT_W-1:0]  target
);
    localparam int PROD_W = DRAW_W + 1 + UNIT_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [PROD_W-1:0] factor;
    logic [PROD_W-1:0] prod;

    always_comb begin
        factor = PROD_W'(draw) + PROD_W'(1);
        prod   = factor * PROD_W'(unit);
    end

    generate
        if (PROD_W > CNT_W) begin : g_sat
            always_comb begin
                if (prod > PROD_W'(CNT_MAX)) target = CNT_MAX;
                else                         target = CNT_W'(prod);
            end
        end else begin : g_wide
            always_comb target = CNT_W'(prod);
        end
    endgenerate
endmodule

// File: rtl/sce_equalizer.sv
module sce_equalizer
    import sce_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int UNIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic              head_begin,
    input  logic              head_end,
    output logic              commit_en,
    input  logic              rand_mode,
    input  logic [UNIT_W-1:0] rand_unit,
    input  logic              seed_load,
    input  logic [15:0]       seed_val,
    input  logic              clear_rec,
    output logic              active,
    output logic [CNT_W-1:0]  rec_len,
    output logic              nest_err
);
    typedef struct packed {
        logic             active;
        logic             rnd;
        logic             err;
        logic [CNT_W-1:0] tgt;
        logic [CNT_W-1:0] rec;
    } eq_state_t;

    eq_state_t st_d, st_q;

    logic [CNT_W-1:0]  elapsed;
    logic [LFSR_W-1:0] lfsr_state;
    logic [CNT_W-1:0]  rand_tgt;
    logic end_here, hold, beg_commit, end_commit, nested;

    always_comb begin
        end_here   = head_valid && head_end && st_q.active;
        hold       = end_here && (elapsed < st_q.tgt);
        end_commit = end_here && !hold;
        beg_commit = head_valid && head_begin && !head_end && !st_q.active;
        nested     = head_valid && head_begin && st_q.active;
    end

    sce_elapsed #(.CNT_W(CNT_W)) u_elapsed (
        .clk   (clk),
        .rst_n (rst_n),
        .start (beg_commit),
        .run   (st_q.active),
        .count (elapsed)
    );

    sce_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (seed_load),
        .seed  (seed_val),
        .step  (beg_commit),
        .state (lfsr_state)
    );

    sce_target #(.CNT_W(CNT_W), .UNIT_W(UNIT_W)) u_target (
        .draw   (lfsr_state[DRAW_W-1:0]),
        .unit   (rand_unit),
        .target (rand_tgt)
    );

    always_comb begin
        st_d = st_q;
        if (beg_commit) begin
            st_d.active = 1'b1;
            st_d.rnd    = rand_mode;
            st_d.tgt    = rand_mode ? rand_tgt : st_q.rec;
        end
        if (end_commit) begin
            st_d.active = 1'b0;
            if (!st_q.rnd && elapsed >= st_q.rec) st_d.rec = elapsed;
        end
        if (nested)    st_d.err = 1'b1;
        if (clear_rec) st_d.rec = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit_en = !hold;
    assign active    = st_q.active;
    assign rec_len   = st_q.rec;
    assign nest_err  = st_q.err;
endmodule

// File: rtl/sce_equalizer_chk.sv
module sce_equalizer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             head_valid,
    input logic             head_begin,
    input logic             head_end,
    input logic             commit_en,
    input logic             clear_rec,
    input logic             active,
    input logic [CNT_W-1:0] rec_len,
    input logic             nest_err
);
    // R1
    stall_only_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_en |-> (active && head_valid && head_end));

    // R2
    close_needs_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $past(head_valid && head_end && commit_en));

    // R2
    open_needs_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(head_valid && head_begin));

    // R3
    rec_still_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_en && !clear_rec) |=> $stable(rec_len));

    // R4
    rec_grows_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_rec |=> rec_len >= $past(rec_len));

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_rec |=> rec_len == '0);

    // R7
    nest_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && head_valid && head_begin) |=> nest_err);

    // R7
    nest_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nest_err |=> nest_err);

    // R8
    stray_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && head_valid && head_end && !clear_rec) |=> ($stable(rec_len) && !active));
endmodule

bind sce_equalizer sce_equalizer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (head_valid),
    .head_begin (head_begin),
    .head_end   (head_end),
    .commit_en  (commit_en),
    .clear_rec  (clear_rec),
    .active     (active),
    .rec_len    (rec_len),
    .nest_err   (nest_err)
);

// File: tb/sim_sce_equalizer.sv
`timescale 1ns/1ps
module sim_sce_equalizer;
    localparam int CNT_W  = 8;
    localparam int UNIT_W = 8;
    localparam int MAXV   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic head_valid = 1'b0, head_begin = 1'b0, head_end = 1'b0;
    logic rand_mode = 1'b0, seed_load = 1'b0, clear_rec = 1'b0;
    logic [UNIT_W-1:0] rand_unit = '0;
    logic [15:0] seed_val = '0;
    logic commit_en, active, nest_err;
    logic [CNT_W-1:0] rec_len;

    int n_run = 0, n_fail = 0;
    int rec_m = 0;
    logic [15:0] lfsr_m = 16'h0001;

    always #4 clk = ~clk;

    sce_equalizer #(.CNT_W(CNT_W), .UNIT_W(UNIT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_begin(head_begin),
        .head_end(head_end), .commit_en(commit_en), .rand_mode(rand_mode),
        .rand_unit(rand_unit), .seed_load(seed_load), .seed_val(seed_val),
        .clear_rec(clear_rec), .active(active), .rec_len(rec_len), .nest_err(nest_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_step(input logic [15:0] s);
        logic [15:0] n;
        n = {1'b0, s[15:1]};
        if (s[0]) n = n ^ 16'hB400;
        return n;
    endfunction

    // Runs one section whose closing marker arrives e cycles after the opening commit.
    // nest_at > 0 places an extra opening marker on that filler slot.
    task automatic section(input int e, input int nest_at, input int exp_dur, input string req);
        int dur;
        @(negedge clk);
        head_valid = 1'b1; head_begin = 1'b1; head_end = 1'b0;
        #1 chk(commit_en == 1'b1, "R1", int'(commit_en), 1);
        @(negedge clk);
        head_begin = 1'b0;
        chk(active == 1'b1, "R2", int'(active), 1);
        for (int i = 1; i < e; i++) begin
            head_begin = (i == nest_at);
            #1 chk(commit_en == 1'b1, "R1", int'(commit_en), 1);
            @(negedge clk);
            head_begin = 1'b0;
        end
        head_end = 1'b1;
        dur = e;
        #1;
        while (!commit_en && dur < 2000) begin
            @(negedge clk);
            #1;
            dur++;
        end
        chk(dur == exp_dur, req, dur, exp_dur);
        @(negedge clk);
        head_end = 1'b0; head_valid = 1'b0;
        chk(active == 1'b0, "R2", int'(active), 0);
    endtask

    task automatic run_default(input int e, input int nest_at);
        int exp_dur;
        string req;
        exp_dur = (e > rec_m) ? e : rec_m;
        req = (e >= rec_m) ? "R4" : "R3";
        if (e > MAXV) req = "R5";
        section(e, nest_at, exp_dur, req);
        if (e > rec_m) rec_m = (e > MAXV) ? MAXV : e;
        chk(int'(rec_len) == rec_m, req, int'(rec_len), rec_m);
    endtask

    task automatic run_rand(input int e);
        int tgt, exp_dur;
        tgt = (int'(lfsr_m[7:0]) + 1) * int'(rand_unit);
        if (tgt > MAXV) tgt = MAXV;
        exp_dur = (e > tgt) ? e : tgt;
        section(e, 0, exp_dur, (e >= tgt) ? "R10" : "R9");
        lfsr_m = model_step(lfsr_m);
        chk(int'(rec_len) == rec_m, "R9", int'(rec_len), rec_m);
    endtask

    task automatic load_seed(input logic [15:0] s);
        @(negedge clk);
        seed_load = 1'b1; seed_val = s;
        @(negedge clk);
        seed_load = 1'b0;
        lfsr_m = (s == 16'h0) ? 16'h0001 : s;
    endtask

    task automatic do_clear;
        @(negedge clk);
        clear_rec = 1'b1;
        @(negedge clk);
        clear_rec = 1'b0;
        rec_m = 0;
        chk(rec_len == '0, "R6", int'(rec_len), 0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(commit_en == 1'b1, "R1", int'(commit_en), 1);
        chk(rec_len == '0, "R6", int'(rec_len), 0);
        chk(active == 1'b0, "R2", int'(active), 0);
        chk(nest_err == 1'b0, "R7", int'(nest_err), 0);

        // Stray closing marker outside any section
        head_valid = 1'b1; head_end = 1'b1;
        #1 chk(commit_en == 1'b1, "R8", int'(commit_en), 1);
        @(negedge clk);
        head_valid = 1'b0; head_end = 1'b0;
        chk(rec_len == '0, "R8", int'(rec_len), 0);
        chk(active == 1'b0, "R8", int'(active), 0);

        // Default-mode sweep of mixed lengths
        for (int i = 0; i < 30; i++) run_default((i * 7) % 23 + 1, 0);
        for (int e = 1; e <= 24; e++) run_default(e, 0);

        // Stray closing marker with a non-zero record
        @(negedge clk);
        head_valid = 1'b1; head_end = 1'b1;
        #1 chk(commit_en == 1'b1, "R8", int'(commit_en), 1);
        @(negedge clk);
        head_valid = 1'b0; head_end = 1'b0;
        chk(int'(rec_len) == rec_m, "R8", int'(rec_len), rec_m);

        do_clear();
        run_default(5, 0);
        run_default(3, 0);

        // Nested opening marker is ignored
        run_default(4, 2);
        chk(nest_err == 1'b1, "R7", int'(nest_err), 1);
        run_default(2, 0);
        chk(nest_err == 1'b1, "R7", int'(nest_err), 1);

        // Saturation
        run_default(300, 0);
        run_default(7, 0);
        run_default(MAXV, 0);

        // Randomized mode
        do_clear();
        run_default(12, 0);
        rand_mode = 1'b1;
        rand_unit = 8'd3;
        load_seed(16'hACE1);
        for (int i = 0; i < 16; i++) run_rand((i * 11) % 37 + 1);
        rand_unit = 8'd1;
        load_seed(16'h0000);
        for (int i = 0; i < 12; i++) run_rand((i * 29) % 90 + 2);
        rand_unit = 8'd200;
        load_seed(16'h5A17);
        for (int i = 0; i < 4; i++) run_rand(i + 3);
        rand_mode = 1'b0;
        run_default(4, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule